// File: doc/BRIEF.md
# Outbound interrupt status aggregator

This block gathers every outbound event that a host may need to service into a single 32-bit status word, and it drives one active-high host interrupt line from that word. Two outbound message registers, an outbound doorbell register and an interrupt mask register are held inside the block. The fill state of the outbound queue prefetch buffer and a firmware interrupt flag arrive as input levels. The firmware flag is kept in a separate reset control register, which is outside this block.

The status bits behave in two ways. The two message bits are sticky: a write to the matching message register sets one, and a write of 1 to the status word clears it. Every other status bit is a read-only image of its source and falls only when that source falls. The mask register stops selected status bits from reaching the interrupt line without changing what the status word reads.

The block has two register ports. The host port decodes registers at their base offsets. The local (internal bus) port decodes the same registers 0x4000 higher. Both ports can read every register. Only the local port writes the message and doorbell registers. Only the host port writes the mask. Either port may clear the sticky status bits.

Top module: `obs_int_aggregator`

## Requirements
- R1: After synchronous reset, the status word, the mask, the doorbell and both message registers read zero, and `host_irq` is 0.
- R2: Status bits 30..8 always read 0, and writing them has no effect. Only mask bits 31 and 7..0 are writable; all other mask bits read 0.
- R3: Status bits 7, 6, 5 and 4 are equal to doorbell bits 3, 2, 1 and 0. They follow the doorbell in the cycle after a doorbell write. Writing 1 to them in the status word has no effect.
- R4: Status bit 2 is 1 exactly when any doorbell software bit (doorbell bits 11..4 with the default `SW_BITS`=8) is 1. Doorbell bits above bit 11 are not stored and read 0.
- R5: Status bit 3 equals `pq_valid` in the same cycle.
- R6: Status bit 31 equals `fw_irq` in the same cycle. Writing 1 to it has no effect.
- R7: A local write to message register 0 (local offset 0x4020) sets status bit 0 from the next cycle. A local write to message register 1 (0x4024) does the same for status bit 1. Each message register reads back the data written to it, on both ports.
- R8: Writing 1 to status bit 0 or 1 through either port clears that bit from the next cycle. Writing 0 leaves the bit unchanged.
- R9: If a message register write and a clear of its status bit happen in the same cycle, the bit ends up set.
- R10: One cycle after the status word or the mask changes, `host_irq` equals the OR over all bits of (status AND NOT mask).
- R11: The host port decodes the registers at offsets message0 0x020, message1 0x024, doorbell 0x02C, status 0x030 and mask 0x034. The local port decodes them at these offsets plus 0x4000, so status is at 0x4030. Any other address reads 0.
- R12: Host writes to the message or doorbell registers are ignored, and local writes to the mask are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host port write strobe |
| h_addr | input | 16 | Host port address |
| h_wdata | input | 32 | Host port write data |
| h_rdata | output | 32 | Host port read data (combinational from address) |
| l_wr | input | 1 | Local port write strobe |
| l_addr | input | 16 | Local port address |
| l_wdata | input | 32 | Local port write data |
| l_rdata | output | 32 | Local port read data (combinational from address) |
| pq_valid | input | 1 | Outbound queue prefetch buffer holds valid data |
| fw_irq | input | 1 | Firmware interrupt flag from the reset control register |
| host_irq | output | 1 | Registered, active-high host interrupt |

## Verification
The situation hardest to bring about from the ports is a set and a clear of the same sticky bit in the same cycle. The bench reaches it by driving a local message write and a host write-1-to-clear on the same clock edge, after first setting both message bits. It then checks that bit 0 survives while bit 1 is cleared. The mask is exercised by a sweep that raises each interrupting source on its own. For each source, the sweep then masks exactly that bit and then every other bit, and it predicts the interrupt line each time from a model of the status word.

// File: rtl/obs_pkg.sv
package obs_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    // Register offsets as seen from the host port.
    localparam logic [ADDR_W-1:0] OFS_MSG0  = 16'h0020;
    localparam logic [ADDR_W-1:0] OFS_MSG1  = 16'h0024;
    localparam logic [ADDR_W-1:0] OFS_DBELL = 16'h002C;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 16'h0030;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 16'h0034;

    // The local port sees the same registers shifted by this base.
    localparam logic [ADDR_W-1:0] HOST_BASE = 16'h0000;
    localparam logic [ADDR_W-1:0] LCL_BASE  = 16'h4000;

    // Status bit positions.
    localparam int B_MSG0 = 0;
    localparam int B_MSG1 = 1;
    localparam int B_SWDB = 2;
    localparam int B_PQ   = 3;
    localparam int B_PINT = 4;
    localparam int B_FW   = 31;

    // Mask bits that can be written.
    localparam logic [DATA_W-1:0] MASK_RW = 32'h8000_00FF;

    typedef struct packed {
        logic msg0;
        logic msg1;
        logic dbell;
        logic stat;
        logic mask;
    } reg_sel_t;

    function automatic logic [DATA_W-1:0] pack_status(
        input logic       fw,
        input logic [3:0] pint,
        input logic       pq,
        input logic       swdb,
        input logic [1:0] msg
    );
        return {fw, 23'd0, pint, pq, swdb, msg};
    endfunction

    function automatic logic [DATA_W-1:0] read_mux(
        input reg_sel_t          sel,
        input logic [DATA_W-1:0] msg0,
        input logic [DATA_W-1:0] msg1,
        input logic [DATA_W-1:0] dbell,
        input logic [DATA_W-1:0] stat,
        input logic [DATA_W-1:0] mask
    );
        return ({DATA_W{sel.msg0}}  & msg0)
             | ({DATA_W{sel.msg1}}  & msg1)
             | ({DATA_W{sel.dbell}} & dbell)
             | ({DATA_W{sel.stat}}  & stat)
             | ({DATA_W{sel.mask}}  & mask);
    endfunction

endpackage

// File: rtl/obs_decode.sv
module obs_decode
    import obs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE = HOST_BASE
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam logic [ADDR_W-1:0] A_MSG0  = BASE + OFS_MSG0;
    localparam logic [ADDR_W-1:0] A_MSG1  = BASE + OFS_MSG1;
    localparam logic [ADDR_W-1:0] A_DBELL = BASE + OFS_DBELL;
    localparam logic [ADDR_W-1:0] A_STAT  = BASE + OFS_STAT;
    localparam logic [ADDR_W-1:0] A_MASK  = BASE + OFS_MASK;

    always_comb begin
        sel.msg0  = (addr == A_MSG0);
        sel.msg1  = (addr == A_MSG1);
        sel.dbell = (addr == A_DBELL);
        sel.stat  = (addr == A_STAT);
        sel.mask  = (addr == A_MASK);
    end
endmodule

// File: rtl/obs_sticky.sv
module obs_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (set[i])
                q[i] <= 1'b1;   // set has priority over clear
            else if (clr[i])
                q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/obs_irq_gate.sv
module obs_irq_gate #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] stat,
    input  logic [W-1:0] mask,
    output logic         irq_q
);
    logic irq_d;

    always_comb irq_d = |(stat & ~mask);

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= irq_d;
    end
endmodule

// File: rtl/obs_int_aggregator.sv
module obs_int_aggregator
    import obs_pkg::*;
#(
    parameter int SW_BITS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_wr,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              pq_valid,
    input  logic              fw_irq,
    output logic              host_irq
);
    localparam int PINT_W = 4;
    localparam int DB_W   = PINT_W + SW_BITS;
    localparam int DB_PAD = DATA_W - DB_W;

    reg_sel_t h_sel, l_sel;

    obs_decode #(.BASE(HOST_BASE)) u_hdec (.addr(h_addr), .sel(h_sel));
    obs_decode #(.BASE(LCL_BASE))  u_ldec (.addr(l_addr), .sel(l_sel));

    logic [DATA_W-1:0] msg0_q, msg1_q, mask_q;
    logic [DB_W-1:0]   dbell_q;
    logic [DATA_W-1:0] dbell_word;
    logic [DATA_W-1:0] stat_word;
    logic [1:0]        msg_set, msg_clr, msg_pend;

    // Storage registers: messages and doorbell from the local side, mask from the host.
    always_ff @(posedge clk) begin
        if (rst) begin
            msg0_q  <= '0;
            msg1_q  <= '0;
            dbell_q <= '0;
            mask_q  <= '0;
        end else begin
            if (l_wr && l_sel.msg0)  msg0_q  <= l_wdata;
            if (l_wr && l_sel.msg1)  msg1_q  <= l_wdata;
            if (l_wr && l_sel.dbell) dbell_q <= l_wdata[DB_W-1:0];
            if (h_wr && h_sel.mask)  mask_q  <= h_wdata & MASK_RW;
        end
    end

    // Sticky message status with write-1-to-clear from either port.
    always_comb begin
        msg_set[B_MSG0] = l_wr && l_sel.msg0;
        msg_set[B_MSG1] = l_wr && l_sel.msg1;
        msg_clr = ({2{h_wr && h_sel.stat}} & h_wdata[1:0])
                | ({2{l_wr && l_sel.stat}} & l_wdata[1:0]);
    end

    obs_sticky #(.N(2)) u_sticky (
        .clk (clk),
        .rst (rst),
        .set (msg_set),
        .clr (msg_clr),
        .q   (msg_pend)
    );

    always_comb begin
        dbell_word = {{DB_PAD{1'b0}}, dbell_q};
        stat_word  = pack_status(fw_irq,
                                 dbell_q[PINT_W-1:0],
                                 pq_valid,
                                 |dbell_q[DB_W-1:PINT_W],
                                 msg_pend);
    end

    always_comb begin
        h_rdata = read_mux(h_sel, msg0_q, msg1_q, dbell_word, stat_word, mask_q);
        l_rdata = read_mux(l_sel, msg0_q, msg1_q, dbell_word, stat_word, mask_q);
    end

    obs_irq_gate #(.W(DATA_W)) u_irq (
        .clk   (clk),
        .rst   (rst),
        .stat  (stat_word),
        .mask  (mask_q),
        .irq_q (host_irq)
    );
endmodule

// File: rtl/obs_int_checker.sv
module obs_int_checker
    import obs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              h_wr,
    input logic [ADDR_W-1:0] h_addr,
    input logic [22:0]       rsvd_rd,
    input logic              l_wr,
    input logic [ADDR_W-1:0] l_addr,
    input logic [3:0]        l_wnib,
    input logic              pq_valid,
    input logic              fw_irq,
    input logic              host_irq,
    input logic [DATA_W-1:0] stat_word,
    input logic [DATA_W-1:0] mask_q
);
    localparam logic [ADDR_W-1:0] L_MSG0  = LCL_BASE + OFS_MSG0;
    localparam logic [ADDR_W-1:0] L_DBELL = LCL_BASE + OFS_DBELL;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (h_addr == OFS_STAT) |-> (rsvd_rd == 23'd0)); // R2

    AST_DB_MIRROR: assert property (@(posedge clk) disable iff (rst)
        (l_wr && l_addr == L_DBELL) |=> (stat_word[7:4] == $past(l_wnib))); // R3

    AST_MSG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (l_wr && l_addr == L_MSG0) |=> stat_word[0]); // R9

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stat_word[0] && !h_wr && !l_wr) |=> stat_word[0]); // R8

    AST_PQ_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        (pq_valid && !mask_q[3]) |=> host_irq); // R10

    AST_FW_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        (fw_irq && !mask_q[31]) |=> host_irq); // R6

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((stat_word & ~mask_q) == '0) |=> !host_irq); // R10
endmodule

bind obs_int_aggregator obs_int_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .h_wr      (h_wr),
    .h_addr    (h_addr),
    .rsvd_rd   (h_rdata[30:8]),
    .l_wr      (l_wr),
    .l_addr    (l_addr),
    .l_wnib    (l_wdata[3:0]),
    .pq_valid  (pq_valid),
    .fw_irq    (fw_irq),
    .host_irq  (host_irq),
    .stat_word (stat_word),
    .mask_q    (mask_q)
);

// File: tb/tb_obs_int_aggregator.sv
module tb_obs_int_aggregator;
    import obs_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        h_wr, l_wr;
    logic [15:0] h_addr, l_addr;
    logic [31:0] h_wdata, l_wdata, h_rdata, l_rdata;
    logic        pq_valid, fw_irq, host_irq;

    obs_int_aggregator dut (
        .clk(clk), .rst(rst),
        .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .pq_valid(pq_valid), .fw_irq(fw_irq), .host_irq(host_irq)
    );

    always #5 clk = ~clk;

    localparam logic [15:0] L = LCL_BASE;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    // Reference model state
    logic [11:0] m_db;
    logic [31:0] m_mask, m_msg0;
    logic [1:0]  m_st;
    logic        m_pq, m_fw;

    function automatic logic [31:0] exp_stat();
        return {m_fw, 23'd0, m_db[3:0], m_pq, |m_db[11:4], m_st};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic lwr(input logic [15:0] a, input logic [31:0] d);
        l_wr = 1'b1; l_addr = a; l_wdata = d;
        @(posedge clk); @(negedge clk);
        l_wr = 1'b0;
    endtask

    task automatic hwr(input logic [15:0] a, input logic [31:0] d);
        h_wr = 1'b1; h_addr = a; h_wdata = d;
        @(posedge clk); @(negedge clk);
        h_wr = 1'b0;
    endtask

    task automatic hrd(input logic [15:0] a, output logic [31:0] d);
        h_addr = a; #1; d = h_rdata;
    endtask

    task automatic lrd(input logic [15:0] a, output logic [31:0] d);
        l_addr = a; #1; d = l_rdata;
    endtask

    task automatic settle(input string tag);
        logic [31:0] r;
        hrd(OFS_STAT, r);
        chk({tag, " status"}, r, exp_stat());
        @(posedge clk); @(negedge clk);
        chk({tag, " irq"}, {31'd0, host_irq}, {31'd0, |(exp_stat() & ~m_mask)});
    endtask

    task automatic raise_src(input int b);
        case (b)
            0:       begin lwr(L + OFS_MSG0, 32'h0000_0BB0); m_msg0 = 32'h0000_0BB0; m_st[0] = 1'b1; end
            1:       begin lwr(L + OFS_MSG1, 32'h0000_0CC1); m_st[1] = 1'b1; end
            2:       begin lwr(L + OFS_DBELL, 32'h0000_0040); m_db = 12'h040; end
            3:       begin pq_valid = 1'b1; m_pq = 1'b1; end
            31:      begin fw_irq = 1'b1; m_fw = 1'b1; end
            default: begin lwr(L + OFS_DBELL, 32'd1 << (b - 4)); m_db = 12'd1 << (b - 4); end
        endcase
    endtask

    task automatic drop_src(input int b);
        case (b)
            0:       begin hwr(OFS_STAT, 32'h1); m_st[0] = 1'b0; end
            1:       begin hwr(OFS_STAT, 32'h2); m_st[1] = 1'b0; end
            3:       begin pq_valid = 1'b0; m_pq = 1'b0; end
            31:      begin fw_irq = 1'b0; m_fw = 1'b0; end
            default: begin lwr(L + OFS_DBELL, 32'h0); m_db = '0; end
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        rst = 1'b1; h_wr = 0; l_wr = 0; h_addr = 0; l_addr = 0; h_wdata = 0; l_wdata = 0;
        pq_valid = 0; fw_irq = 0;
        m_db = '0; m_mask = '0; m_msg0 = '0; m_st = '0; m_pq = 0; m_fw = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        hrd(OFS_STAT, r);        chk("R1 status", r, 32'h0);
        chk("R1 irq", {31'd0, host_irq}, 32'h0);
        hrd(OFS_MASK, r);        chk("R1 mask", r, 32'h0);
        lrd(L + OFS_DBELL, r);   chk("R1 doorbell", r, 32'h0);
        lrd(L + OFS_MSG0, r);    chk("R1 msg0", r, 32'h0);

        // R11 decode on both ports
        fw_irq = 1'b1; m_fw = 1'b1;
        hrd(OFS_STAT, r);        chk("R11 host status", r, 32'h8000_0000);
        lrd(L + OFS_STAT, r);    chk("R11 local status", r, 32'h8000_0000);
        hrd(L + OFS_STAT, r);    chk("R11 host unmapped", r, 32'h0);
        lrd(OFS_STAT, r);        chk("R11 local unmapped", r, 32'h0);
        hrd(16'h0038, r);        chk("R11 gap", r, 32'h0);

        // R6 firmware mirror
        settle("R6 fw set");
        hwr(OFS_STAT, 32'h8000_0000);
        settle("R6 fw w1c ignored");
        fw_irq = 1'b0; m_fw = 1'b0;
        settle("R6 fw clear");

        // R5 prefetch valid mirror
        pq_valid = 1'b1; m_pq = 1'b1;
        settle("R5 pq set");
        pq_valid = 1'b0; m_pq = 1'b0;
        settle("R5 pq clear");

        // R3 exhaustive pin-interrupt nibble
        for (int v = 0; v < 16; v++) begin
            lwr(L + OFS_DBELL, v);
            m_db = v[11:0];
            settle($sformatf("R3 nibble %0d", v));
        end
        hwr(OFS_STAT, 32'h0000_00F0);
        settle("R3 w1c ignored");
        lwr(L + OFS_DBELL, 32'h0); m_db = '0;
        settle("R3 cleared");

        // R4 software doorbell bits
        for (int i = 0; i < 8; i++) begin
            lwr(L + OFS_DBELL, 32'd1 << (4 + i));
            m_db = 12'd1 << (4 + i);
            settle($sformatf("R4 sw bit %0d", i));
        end
        lwr(L + OFS_DBELL, 32'hFFFF_F000); m_db = '0;
        settle("R4 upper bits not stored");
        lrd(L + OFS_DBELL, r);   chk("R4 doorbell read", r, 32'h0);

        // R7 message writes set sticky bits
        lwr(L + OFS_MSG0, 32'hA5A5_0001); m_msg0 = 32'hA5A5_0001; m_st[0] = 1'b1;
        settle("R7 msg0 set");
        hrd(OFS_MSG0, r);        chk("R7 msg0 data host", r, 32'hA5A5_0001);
        lwr(L + OFS_MSG1, 32'h1234_5678); m_st[1] = 1'b1;
        settle("R7 msg1 set");
        lrd(L + OFS_MSG1, r);    chk("R7 msg1 data local", r, 32'h1234_5678);

        // R8 write-1-to-clear
        hwr(OFS_STAT, 32'h0);
        settle("R8 zero write");
        hwr(OFS_STAT, 32'h2); m_st[1] = 1'b0;
        settle("R8 host clear bit1");
        lwr(L + OFS_STAT, 32'h1); m_st[0] = 1'b0;
        settle("R8 local clear bit0");

        // R9 set beats clear in the same cycle
        lwr(L + OFS_MSG0, 32'h0000_0011); m_msg0 = 32'h0000_0011;
        lwr(L + OFS_MSG1, 32'h0000_0022);
        m_st = 2'b11;
        settle("R9 both set");
        l_wr = 1'b1; l_addr = L + OFS_MSG0; l_wdata = 32'h0000_0033;
        h_wr = 1'b1; h_addr = OFS_STAT;     h_wdata = 32'h3;
        @(posedge clk); @(negedge clk);
        l_wr = 1'b0; h_wr = 1'b0;
        m_msg0 = 32'h0000_0033; m_st = 2'b01;
        settle("R9 set wins");
        hwr(OFS_STAT, 32'h1); m_st = 2'b00;
        settle("R9 cleanup");

        // R12 write permissions
        hwr(OFS_MSG0, 32'hDEAD_BEEF);
        lrd(L + OFS_MSG0, r);    chk("R12 host msg write ignored", r, m_msg0);
        hwr(OFS_DBELL, 32'h0000_000F);
        settle("R12 host doorbell write ignored");
        lwr(L + OFS_MASK, 32'hFFFF_FFFF);
        hrd(OFS_MASK, r);        chk("R12 local mask write ignored", r, 32'h0);

        // R2 reserved bits
        hwr(OFS_MASK, 32'hFFFF_FFFF); m_mask = 32'hFFFF_FFFF & MASK_RW;
        hrd(OFS_MASK, r);        chk("R2 mask writable bits", r, 32'h8000_00FF);
        hwr(OFS_STAT, 32'h7FFF_FF00);
        settle("R2 reserved status write");
        hwr(OFS_MASK, 32'h0); m_mask = '0;

        // R10 mask sweep over every interrupting bit
        for (int k = 0; k < 9; k++) begin
            int b;
            b = (k == 8) ? 31 : k;
            raise_src(b);
            settle($sformatf("R10 bit %0d unmasked", b));
            hwr(OFS_MASK, 32'd1 << b); m_mask = 32'd1 << b;
            settle($sformatf("R10 bit %0d masked", b));
            hwr(OFS_MASK, ~(32'd1 << b)); m_mask = ~(32'd1 << b) & MASK_RW;
            settle($sformatf("R10 bit %0d others masked", b));
            hwr(OFS_MASK, 32'h0); m_mask = '0;
            drop_src(b);
            settle($sformatf("R10 bit %0d dropped", b));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule